// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is a small general-purpose I/O port with a byte-wide memory-mapped register bus. It holds one direction bit and one output data bit per pin. It drives each pad's output value and output enable from those registers. It samples the pad inputs through a synchroniser.

The output data is reached through a window of word addresses, not a single register. The word address of an access acts as a pin mask. Address bit n+2 selects pin n. A write changes only the selected pins, so one pin can be set or cleared in a single bus write, with no read-modify-write sequence. A read returns only the selected pins and reads every other bit position as zero.

A data write cannot change a pin that is currently an input. Software therefore sets the direction bit first and then writes the value. Read data is registered and appears in the cycle after the read.

Top module: `gpio_masked_port`

## Requirements
- R1: With default parameters the port has 8 pins. While reset is asserted, and in the cycle after it, `pad_oe`, `pad_out` and `bus_rdata` are all zero. Every pin therefore starts as an input.
- R2: Byte offset 0x400 holds the direction register, where bit n = 1 makes pin n an output. After a write there, `pad_oe` equals the written byte. A read there returns the current direction.
- R3: A write to any offset below 0x400 is a data write. For every pin n that is an output and whose address bit n+2 is 1, `pad_out[n]` takes `bus_wdata[n]` in the cycle after the write.
- R4: A data write leaves unchanged every pin whose address bit n+2 is 0.
- R5: A data write leaves the stored value of a selected input pin unchanged. After that pin is switched to output, `pad_out` shows the value stored before the ignored write.
- R6: A data read returns, for each selected output pin, the stored output value.
- R7: A data read returns, for each selected input pin, the pad value after a two-stage synchroniser. A pad change is not visible to a read issued in the same cycle. It is visible to a read issued two cycles later.
- R8: A data read returns zero in every bit position whose address bit n+2 is 0.
- R9: Address bits [1:0] have no effect on decode. For example, offset 0x007 acts as 0x004, and 0x401 acts as 0x400.
- R10: Offsets 0x404 and above are unmapped. Reads there return zero, and writes there change neither `pad_out` nor `pad_oe`.
- R11: `bus_rdata` is valid only in the cycle after a read access and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | NUM_PINS (8) | Write data |
| bus_rdata | output | NUM_PINS (8) | Registered read data |
| pad_in | input | NUM_PINS (8) | Asynchronous pad input values |
| pad_out | output | NUM_PINS (8) | Pad output values |
| pad_oe | output | NUM_PINS (8) | Pad output enables, 1 = drive |

## Verification
The bench builds the block with its defaults: 8 pins, a 12-bit byte address and two synchroniser stages. With these values, all 256 pin-mask patterns of the data window lie inside a 4 KiB map. So do the direction word and its aliases and a large unmapped region above them. Random accesses therefore cover every mask against mixed direction settings. Directed cases pin down the synchroniser latency, the ignored input writes and the address-bit aliases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Which register an access targets.
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2
  } gpio_region_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output gpio_region_e        region,
  output logic [NUM_PINS-1:0] pin_mask
);

  // Byte lanes are ignored: decode on the word address only.
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << NUM_PINS);

  logic [WORD_W-1:0] word;

  assign word     = addr[ADDR_W-1:2];
  assign pin_mask = word[NUM_PINS-1:0];

  always_comb begin
    if (word < DIR_WORD)       region = RGN_DATA;
    else if (word == DIR_WORD) region = RGN_DIR;
    else                       region = RGN_NONE;
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_dir,
  input  logic                wr_data,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  // A bit changes only if its pin is selected and currently an output.
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
    logic upd;
    assign upd = wr_data & pin_mask[n] & dir_q[n];
    always_ff @(posedge clk) begin
      if (rst)      data_q[n] <= 1'b0;
      else if (upd) data_q[n] <= wdata[n];
    end
  end

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  gpio_region_e        region,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] data_q,
  input  logic [NUM_PINS-1:0] pins_sync,
  output logic [NUM_PINS-1:0] rdata_q
);

  logic [NUM_PINS-1:0] pin_val;
  logic [NUM_PINS-1:0] rd_next;

  // Output pins report the driven value, input pins the synchronised pad.
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_val
    assign pin_val[n] = dir_q[n] ? data_q[n] : pins_sync[n];
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      case (region)
        RGN_DATA: rd_next = pin_val & pin_mask;
        RGN_DIR:  rd_next = dir_q;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  gpio_region_e        region;
  logic [NUM_PINS-1:0] pin_mask;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] data_q;
  logic [NUM_PINS-1:0] pins_sync;
  logic                wr_dir;
  logic                wr_data;
  logic                rd_en;

  gpio_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .addr     (bus_addr),
    .region   (region),
    .pin_mask (pin_mask)
  );

  assign wr_dir  = bus_sel & bus_wr & (region == RGN_DIR);
  assign wr_data = bus_sel & bus_wr & (region == RGN_DATA);
  assign rd_en   = bus_sel & ~bus_wr;

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_dir   (wr_dir),
    .wr_data  (wr_data),
    .pin_mask (pin_mask),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .data_q   (data_q)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pins_sync)
  );

  gpio_readmux #(.NUM_PINS(NUM_PINS)) u_readmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .region    (region),
    .pin_mask  (pin_mask),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .pins_sync (pins_sync),
    .rdata_q   (bus_rdata)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << NUM_PINS);

  logic [WORD_W-1:0]   word;
  logic                in_data;
  logic                in_dir;
  logic                in_none;
  logic [NUM_PINS-1:0] sel_mask;

  assign word     = bus_addr[ADDR_W-1:2];
  assign in_data  = word < DIR_WORD;
  assign in_dir   = word == DIR_WORD;
  assign in_none  = word > DIR_WORD;
  assign sel_mask = word[NUM_PINS-1:0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && in_dir |=> pad_oe == $past(bus_wdata));

  assert_dir_read_R2: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && in_dir |=> bus_rdata == $past(pad_oe));

  assert_masked_update_R3: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && in_data |=>
      ((pad_out ^ $past(bus_wdata)) & $past(sel_mask & pad_oe)) == '0);

  // Covers both R4 (unselected pins) and R5 (selected input pins).
  assert_other_hold_R4: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && in_data |=>
      ((pad_out ^ $past(pad_out)) & ~$past(sel_mask & pad_oe)) == '0);

  assert_read_output_R6: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && in_data |=>
      ((bus_rdata ^ $past(pad_out)) & $past(sel_mask & pad_oe)) == '0);

  assert_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && in_data |=> (bus_rdata & ~$past(sel_mask)) == '0);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    bus_sel && in_none |=> $stable(pad_out) && $stable(pad_oe) && bus_rdata == '0);

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> bus_rdata == '0);

endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_masked_port_test.sv
`timescale 1ns/1ps
module gpio_masked_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks = 0;
  int errors = 0;

  // Bench model of the port state.
  logic [7:0] m_dir = '0;
  logic [7:0] m_data = '0;

  always #2 clk = ~clk;

  gpio_masked_port uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [11:0] a);
    logic [7:0] m;
    if (a[11:10] == 2'b00) begin
      m = a[9:2];
      return ((m_dir & m_data) | (~m_dir & pad_in)) & m;
    end else if (a[11:2] == 10'h100) begin
      return m_dir;
    end
    return 8'h00;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] en;
    if (a[11:10] == 2'b00) begin
      en = a[9:2] & m_dir;
      m_data = (m_data & ~en) | (d & en);
    end else if (a[11:2] == 10'h100) begin
      m_dir = d;
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a);
    logic [7:0] d;
    logic [7:0] e;
    e = exp_read(a);
    do_read(a, d);
    chk(req, d, e);
  endtask

  task automatic set_pads(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] old_pads;
    logic [31:0] seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    chk("R1 reset pad_oe", pad_oe, 8'h00);
    chk("R1 reset pad_out", pad_out, 8'h00);
    chk("R1 reset rdata", bus_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    // R2: direction write and read-back
    do_write(12'h400, 8'h0F);
    chk("R2 pad_oe after dir write", pad_oe, 8'h0F);
    read_chk("R2 dir read", 12'h400);
    // R9: byte-lane bits ignored on direction word
    read_chk("R9 dir alias 0x403", 12'h403);

    // R3/R5: full-mask write, only output pins change
    do_write(12'h3FC, 8'hFF);
    chk("R3 full mask write", pad_out, 8'h0F);
    // R4: single-pin mask clears pin 0 only
    do_write(12'h004, 8'h00);
    chk("R4 single pin write", pad_out, 8'h0E);
    // R9: offset 0x007 acts as 0x004
    do_write(12'h007, 8'h01);
    chk("R9 low bits ignored", pad_out, 8'h0F);
    // R5: upper pins kept old value 0 after switching to output
    do_write(12'h400, 8'hFF);
    chk("R5 stale input write dropped", pad_out, 8'h0F);
    do_write(12'h3C0, 8'hA0);
    chk("R5 rewrite after output", pad_out, 8'hAF);

    // R6/R7/R8: mixed direction reads
    do_write(12'h400, 8'h0F);
    set_pads(8'hA5);
    read_chk("R6 R7 full mask read", 12'h3FC);
    read_chk("R8 partial mask read", 12'h0C0);
    read_chk("R8 empty mask read", 12'h000);

    // R7: change not visible to a read issued in the same cycle
    old_pads = pad_in;
    @(negedge clk);
    pad_in = 8'h5A;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3C0;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R7 sync latency old value", bus_rdata, old_pads & 8'hF0);
    @(negedge clk);
    read_chk("R7 sync new value", 12'h3C0);

    // R10: unmapped offsets
    do_write(12'h800, 8'hFF);
    chk("R10 unmapped write oe", pad_oe, 8'h0F);
    chk("R10 unmapped write out", pad_out, 8'hAF);
    read_chk("R10 unmapped read 0x404", 12'h404);
    read_chk("R10 unmapped read 0xFFC", 12'hFFC);

    // R11: idle cycle after read returns zero
    do_read(12'h400, d);
    @(negedge clk);
    chk("R11 rdata idle", bus_rdata, 8'h00);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [11:0] a;
      logic [7:0] v;
      kind = $urandom % 8;
      v = 8'($urandom);
      case (kind)
        5:       a = 12'h400 | 12'($urandom % 4);
        6:       a = 12'h404 + 12'($urandom % 12'hBFC);
        default: a = {2'b00, 10'($urandom)};
      endcase
      if (kind == 7) begin
        set_pads(v);
      end else if ($urandom % 2 == 0) begin
        do_write(a, v);
        chk("R3 R4 R5 random write out", pad_out, m_data);
        chk("R2 R10 random write oe", pad_oe, m_dir);
      end else begin
        read_chk("R6 R7 R8 R10 random read", a);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule